// File: doc/BRIEF.md
# I2C bus status and address-match tracker

This block sits beside an I2C controller and keeps the status word that a processor reads. It watches already-synchronized SCL and SDA lines and finds START, repeated START and STOP conditions. It counts the clock pulses of each byte and captures the first byte after a START as the calling address. That address is compared with a programmed slave address and with the all-zero broadcast address. From these events it keeps eight flags:
- transfer done
- addressed as slave
- bus busy
- arbitration lost
- broadcast call
- slave direction
- interrupt pending
- received NACK

A small register interface presents the status word at all times and accepts two writes. A status write clears the two software-clearable flags. A control write sets interrupt enable and broadcast enable, and as a side effect it drops the addressed-as-slave indication. An arbitration-loss pulse from the master logic sets a sticky flag. The block never drives the bus and never retries a lost transfer.

Top module: `i2c_stat_tracker`

## Requirements
- R1: Bus busy (stat_o[5]) goes to 1 after SDA falls while SCL is high (START) and goes to 0 after SDA rises while SCL is high (STOP).
- R2: Transfer done (stat_o[7]) goes to 0 at the falling SCL edge that closes the first bit of a byte. It goes to 1 at the falling SCL edge that closes the ninth clock, and not at the ninth rising edge.
- R3: Addressed as slave (stat_o[6]) goes to 1 when the seven high bits of the first byte after a START or repeated START equal own_addr_i. Later bytes of the same transfer are not compared. Any control write clears it.
- R4: Broadcast call (stat_o[3]) goes to 1 together with stat_o[6] when the seven address bits are all zero, broadcast enable (ctrl_wdata_i[1]) is set, and own_addr_i does not match. With broadcast enable clear, an all-zero address sets neither flag. A control write clears it.
- R5: Slave direction (stat_o[2]) takes the eighth bit of the address byte whenever stat_o[6] is set by that byte: 1 means the master reads and 0 means the master writes.
- R6: Arbitration lost (stat_o[4]) is set by a pulse on arb_lost_i. It stays set through control writes and through status writes with bit 4 at 1, and only a status write with bit 4 at 0 clears it.
- R7: In a status write only bits 4 and 1 take effect, and only a 0 in them clears. All other bits are ignored.
- R8: After reset stat_o reads 8'h81 (transfer done and received NACK at 1) and irq_o is 0.
- R9: Interrupt pending (stat_o[1], mirrored on irq_o) is set at each byte completion and on each arbitration loss while interrupt enable (ctrl_wdata_i[0] of the last control write) is 1. A status write with bit 1 at 0 clears it.
- R10: Received NACK (stat_o[0]) takes the SDA level at the ninth rising SCL edge of each byte: 1 is NACK and 0 is ACK.
- R11: A repeated START in the middle of a byte restarts bit counting, so the next full byte is treated as a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| arb_lost_i | input | 1 | One-cycle pulse: arbitration was lost |
| own_addr_i | input | ADDR_W | Programmed 7-bit slave address |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 2 | Control data: bit 0 interrupt enable, bit 1 broadcast enable |
| stat_we_i | input | 1 | Status write strobe (clears flags) |
| stat_wdata_i | input | 8 | Status write data, same bit positions as stat_o |
| stat_o | output | 8 | Status word, registered |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
Every flag changes at the first rising clock edge that sees the new line level or the write strobe. It is therefore readable one cycle after the stimulus is applied, with no further pipeline stage. The bench changes the bus lines and strobes just after a falling clock edge and holds each line level for three clocks. It samples stat_o at a falling edge once at least one rising edge has passed. For transfer done it also samples between the ninth rising and falling SCL edges, to confirm that the flag waits for the falling edge.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

  // Status word bit positions (bit 7 is the most significant)
  localparam int ST_W     = 8;
  localparam int ST_DONE  = 7;
  localparam int ST_ADDRD = 6;
  localparam int ST_BUSY  = 5;
  localparam int ST_ARBL  = 4;
  localparam int ST_GCALL = 3;
  localparam int ST_DIR   = 2;
  localparam int ST_IRQ   = 1;
  localparam int ST_NACK  = 0;

  // Control register fields
  localparam int CTL_W     = 2;
  localparam int CTL_IEN   = 0;
  localparam int CTL_BCAST = 1;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;

endpackage

// File: rtl/i2c_edge_det.sv
module i2c_edge_det
  import i2c_stat_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    evt_o.start = scl_q & scl_i & sda_q & ~sda_i;
    evt_o.stop  = scl_q & scl_i & ~sda_q & sda_i;
    evt_o.rise  = scl_i & ~scl_q;
    evt_o.fall  = ~scl_i & scl_q;
  end

endmodule

// File: rtl/i2c_bit_tracker.sv
module i2c_bit_tracker
  import i2c_stat_pkg::*;
#(
  parameter int BYTE_BITS = 8,
  localparam int CNT_W    = $clog2(BYTE_BITS + 2)
)(
  input  logic                 clk,
  input  logic                 rst,
  input  bus_evt_t             evt_i,
  input  logic                 sda_i,
  output logic                 byte_open_o,
  output logic                 ack_smp_o,
  output logic                 byte_end_o,
  output logic                 first_byte_o,
  output logic [BYTE_BITS-1:0] shreg_o
);

  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0]     cnt_q;
  logic [BYTE_BITS-1:0] sh_q;
  logic                 first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      first_q <= 1'b0;
    end else if (evt_i.start || evt_i.stop) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      first_q <= evt_i.start;
    end else if (evt_i.rise) begin
      if (cnt_q != CNT_LAST) cnt_q <= cnt_q + CNT_ONE;
      if (cnt_q < CNT_ACK)   sh_q  <= {sh_q[BYTE_BITS-2:0], sda_i};
    end else if (evt_i.fall && cnt_q == CNT_LAST) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end
  end

  assign byte_open_o  = evt_i.fall && (cnt_q == CNT_ONE);
  assign ack_smp_o    = evt_i.rise && (cnt_q == CNT_ACK);
  assign byte_end_o   = evt_i.fall && (cnt_q == CNT_LAST) && !evt_i.start && !evt_i.stop;
  assign first_byte_o = first_q;
  assign shreg_o      = sh_q;

  AST_NEW_FRAME: assert property (@(posedge clk) disable iff (rst)
    evt_i.start |=> (cnt_q == '0) && first_q); // R11

endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank
  import i2c_stat_pkg::*;
#(
  parameter int ADDR_W = 7
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_evt_i,
  input  logic              stop_evt_i,
  input  logic              byte_open_i,
  input  logic              ack_smp_i,
  input  logic              byte_end_i,
  input  logic              first_byte_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dir_bit_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ien_i,
  input  logic              bcast_en_i,
  input  logic              arb_lost_i,
  input  logic              ctrl_wr_i,
  input  logic              clr_arbl_i,
  input  logic              clr_irq_i,
  output logic [ST_W-1:0]   stat_o
);

  logic done_q, addrd_q, busy_q, arbl_q, gcall_q, dir_q, irq_q, nack_q;
  logic own_hit, gc_hit, any_hit;

  always_comb begin
    own_hit = byte_end_i && first_byte_i && (addr_i == own_addr_i);
    gc_hit  = byte_end_i && first_byte_i && bcast_en_i &&
              (addr_i == '0) && (addr_i != own_addr_i);
    any_hit = own_hit || gc_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b1;
      addrd_q <= 1'b0;
      busy_q  <= 1'b0;
      arbl_q  <= 1'b0;
      gcall_q <= 1'b0;
      dir_q   <= 1'b0;
      irq_q   <= 1'b0;
      nack_q  <= 1'b1;
    end else begin
      if (start_evt_i)     busy_q <= 1'b1;
      else if (stop_evt_i) busy_q <= 1'b0;

      if (byte_end_i)       done_q <= 1'b1;
      else if (byte_open_i) done_q <= 1'b0;

      if (ack_smp_i) nack_q <= sda_i;

      if (any_hit)        addrd_q <= 1'b1;
      else if (ctrl_wr_i) addrd_q <= 1'b0;

      if (gc_hit)         gcall_q <= 1'b1;
      else if (ctrl_wr_i) gcall_q <= 1'b0;

      if (any_hit) dir_q <= dir_bit_i;

      if (arb_lost_i)      arbl_q <= 1'b1;
      else if (clr_arbl_i) arbl_q <= 1'b0;

      if (ien_i && (byte_end_i || arb_lost_i)) irq_q <= 1'b1;
      else if (clr_irq_i)                      irq_q <= 1'b0;
    end
  end

  always_comb begin
    stat_o           = '0;
    stat_o[ST_DONE]  = done_q;
    stat_o[ST_ADDRD] = addrd_q;
    stat_o[ST_BUSY]  = busy_q;
    stat_o[ST_ARBL]  = arbl_q;
    stat_o[ST_GCALL] = gcall_q;
    stat_o[ST_DIR]   = dir_q;
    stat_o[ST_IRQ]   = irq_q;
    stat_o[ST_NACK]  = nack_q;
  end

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (rst)
    start_evt_i |=> busy_q); // R1
  AST_BUSY_CLR: assert property (@(posedge clk) disable iff (rst)
    stop_evt_i |=> !busy_q); // R1
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    byte_end_i |=> done_q); // R2
  AST_ADDRD_CLR: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr_i && !any_hit) |=> !addrd_q); // R3
  AST_GCALL_ADDRD: assert property (@(posedge clk) disable iff (rst)
    gcall_q |-> addrd_q); // R4
  AST_ARBL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (arbl_q && !clr_arbl_i) |=> arbl_q); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (!ien_i && !irq_q) |=> !irq_q); // R9

endmodule

// File: rtl/i2c_stat_tracker.sv
module i2c_stat_tracker
  import i2c_stat_pkg::*;
#(
  parameter int  BYTE_BITS = 8,
  localparam int ADDR_W    = BYTE_BITS - 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              arb_lost_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ctrl_we_i,
  input  logic [CTL_W-1:0]  ctrl_wdata_i,
  input  logic              stat_we_i,
  input  logic [ST_W-1:0]   stat_wdata_i,
  output logic [ST_W-1:0]   stat_o,
  output logic              irq_o
);

  bus_evt_t             evt;
  logic                 byte_open, ack_smp, byte_end, first_byte;
  logic [BYTE_BITS-1:0] shreg;
  logic [CTL_W-1:0]     ctrl_q;
  logic                 clr_arbl, clr_irq;
  logic                 unused_wbits;

  always_ff @(posedge clk) begin
    if (rst)            ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
  end

  assign clr_arbl     = stat_we_i && !stat_wdata_i[ST_ARBL];
  assign clr_irq      = stat_we_i && !stat_wdata_i[ST_IRQ];
  assign unused_wbits = ^{stat_wdata_i[7:5], stat_wdata_i[3:2], stat_wdata_i[0]};

  i2c_edge_det u_edge (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt_o (evt)
  );

  i2c_bit_tracker #(.BYTE_BITS(BYTE_BITS)) u_bits (
    .clk          (clk),
    .rst          (rst),
    .evt_i        (evt),
    .sda_i        (sda_i),
    .byte_open_o  (byte_open),
    .ack_smp_o    (ack_smp),
    .byte_end_o   (byte_end),
    .first_byte_o (first_byte),
    .shreg_o      (shreg)
  );

  i2c_flag_bank #(.ADDR_W(ADDR_W)) u_flags (
    .clk          (clk),
    .rst          (rst),
    .start_evt_i  (evt.start),
    .stop_evt_i   (evt.stop),
    .byte_open_i  (byte_open),
    .ack_smp_i    (ack_smp),
    .byte_end_i   (byte_end),
    .first_byte_i (first_byte),
    .sda_i        (sda_i),
    .addr_i       (shreg[BYTE_BITS-1:1]),
    .dir_bit_i    (shreg[0]),
    .own_addr_i   (own_addr_i),
    .ien_i        (ctrl_q[CTL_IEN]),
    .bcast_en_i   (ctrl_q[CTL_BCAST]),
    .arb_lost_i   (arb_lost_i),
    .ctrl_wr_i    (ctrl_we_i),
    .clr_arbl_i   (clr_arbl),
    .clr_irq_i    (clr_irq),
    .stat_o       (stat_o)
  );

  assign irq_o = stat_o[ST_IRQ];

endmodule

// File: tb/i2c_stat_tracker_tb_top.sv
module i2c_stat_tracker_tb_top;

  localparam int B_DONE = 7, B_ADDRD = 6, B_BUSY = 5, B_ARBL = 4;
  localparam int B_GCALL = 3, B_DIR = 2, B_IRQ = 1, B_NACK = 0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1, sda = 1'b1, arb = 1'b0;
  logic [6:0] own = 7'h2A;
  logic       cwe = 1'b0, swe = 1'b0;
  logic [1:0] cwd = '0;
  logic [7:0] swd = '0;
  logic [7:0] stat;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_stat_tracker dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .arb_lost_i(arb),
    .own_addr_i(own), .ctrl_we_i(cwe), .ctrl_wdata_i(cwd),
    .stat_we_i(swe), .stat_wdata_i(swd), .stat_o(stat), .irq_o(irq)
  );

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_match(input logic [6:0] a, input logic [6:0] o,
                                           input logic bc);
    logic hit_own, hit_gc;
    hit_own = (a == o);
    hit_gc  = bc && (a == 7'd0) && !hit_own;
    return {hit_own | hit_gc, hit_gc};
  endfunction

  task automatic lines(input logic s, input logic d);
    @(negedge clk);
    scl = s;
    sda = d;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_start();
    lines(1, 1); lines(1, 0); lines(0, 0);
  endtask

  task automatic bus_rstart();
    lines(0, 1); lines(1, 1); lines(1, 0); lines(0, 0);
  endtask

  task automatic bus_stop();
    lines(0, 0); lines(1, 0); lines(1, 1);
  endtask

  task automatic bus_bit(input logic b);
    lines(0, b); lines(1, b); lines(0, b);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) begin
      bus_bit(v[i]);
      if (i == 7) chk("R2 done low in byte", {7'd0, stat[B_DONE]}, 8'd0);
    end
    lines(0, ack);
    lines(1, ack);
    chk("R2 done not at ninth rise", {7'd0, stat[B_DONE]}, 8'd0);
    chk("R10 nack sample", {7'd0, stat[B_NACK]}, {7'd0, ack});
    lines(0, ack);
    chk("R2 done at ninth fall", {7'd0, stat[B_DONE]}, 8'd1);
  endtask

  task automatic wr_ctrl(input logic [1:0] v);
    @(negedge clk); cwe = 1'b1; cwd = v;
    @(negedge clk); cwe = 1'b0;
  endtask

  task automatic wr_stat(input logic [7:0] v);
    @(negedge clk); swe = 1'b1; swd = v;
    @(negedge clk); swe = 1'b0;
  endtask

  task automatic pulse_arb();
    @(negedge clk); arb = 1'b1;
    @(negedge clk); arb = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [1:0] m;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset status", stat, 8'h81);
    chk("R8 reset irq", {7'd0, irq}, 8'd0);

    // R7: writes to read-only bits ignored
    wr_stat(8'h00);
    chk("R7 zeros ignored", stat, 8'h81);
    wr_stat(8'hFF);
    chk("R7 ones ignored", stat, 8'h81);

    // R6 / R9: arbitration loss
    wr_ctrl(2'b01);
    pulse_arb();
    chk("R6 arbl set", {7'd0, stat[B_ARBL]}, 8'd1);
    chk("R9 irq on arb loss", {7'd0, irq}, 8'd1);
    wr_stat(8'hFF);
    chk("R6 arbl kept by write 1", {7'd0, stat[B_ARBL]}, 8'd1);
    wr_ctrl(2'b00);
    chk("R6 arbl kept by ctrl write", {7'd0, stat[B_ARBL]}, 8'd1);
    wr_stat(8'hEF);
    chk("R6 arbl cleared", {7'd0, stat[B_ARBL]}, 8'd0);
    chk("R9 irq kept", {7'd0, stat[B_IRQ]}, 8'd1);
    wr_stat(8'hFD);
    chk("R9 irq cleared", {7'd0, irq}, 8'd0);
    pulse_arb();
    chk("R9 no irq when disabled", {7'd0, irq}, 8'd0);
    wr_stat(8'h00);

    // R11 / R5: repeated START mid-byte, then read address
    bus_start();
    chk("R1 busy after start", {7'd0, stat[B_BUSY]}, 8'd1);
    for (int i = 0; i < 4; i++) bus_bit(1'b0);
    bus_rstart();
    send_byte({own, 1'b1}, 1'b0);
    chk("R11 address after rstart", {7'd0, stat[B_ADDRD]}, 8'd1);
    chk("R5 master reads", {7'd0, stat[B_DIR]}, 8'd1);
    bus_stop();
    chk("R1 busy after stop", {7'd0, stat[B_BUSY]}, 8'd0);
    chk("R3 stop keeps addrd", {7'd0, stat[B_ADDRD]}, 8'd1);

    // R4: all-zero address with broadcast disabled, then enabled
    wr_ctrl(2'b00);
    chk("R3 ctrl write clears", {7'd0, stat[B_ADDRD]}, 8'd0);
    bus_start();
    send_byte(8'h00, 1'b0);
    chk("R4 no bcast when disabled", {6'd0, stat[B_ADDRD], stat[B_GCALL]}, 8'd0);
    bus_stop();
    wr_ctrl(2'b10);
    bus_start();
    send_byte(8'h00, 1'b0);
    chk("R4 bcast hit", {6'd0, stat[B_ADDRD], stat[B_GCALL]}, 8'd3);
    chk("R5 master writes", {7'd0, stat[B_DIR]}, 8'd0);
    bus_stop();

    // Random transactions
    for (int t = 0; t < 24; t++) begin
      logic [6:0] a;
      logic rw, ak, ien, bc;
      logic [7:0] db;
      case ($urandom % 4)
        0: a = own;
        1: a = 7'd0;
        default: a = 7'($urandom);
      endcase
      rw  = 1'($urandom);
      ak  = 1'($urandom);
      ien = 1'($urandom);
      bc  = 1'($urandom);
      db  = 8'($urandom);
      wr_ctrl({bc, ien});
      chk("R3 cleared by ctrl write", {6'd0, stat[B_ADDRD], stat[B_GCALL]}, 8'd0);
      wr_stat(8'h00);
      chk("R9 irq cleared", {7'd0, irq}, 8'd0);
      bus_start();
      chk("R1 busy set", {7'd0, stat[B_BUSY]}, 8'd1);
      send_byte({a, rw}, ak);
      m = exp_match(a, own, bc);
      chk("R3 address match", {7'd0, stat[B_ADDRD]}, {7'd0, m[1]});
      chk("R4 broadcast flag", {7'd0, stat[B_GCALL]}, {7'd0, m[0]});
      if (m[1]) chk("R5 direction", {7'd0, stat[B_DIR]}, {7'd0, rw});
      chk("R9 irq after byte", {7'd0, irq}, {7'd0, ien});
      send_byte({db[7:1], ~m[1]}, 1'b1);
      chk("R3 data byte not compared", {7'd0, stat[B_ADDRD]}, {7'd0, m[1]});
      bus_stop();
      chk("R1 busy cleared", {7'd0, stat[B_BUSY]}, 8'd0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule